// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation vectors by a weight matrix that it holds in place. It is a parameterized square grid of multiply-accumulate cells (4 by 4 by default). Weights are first shifted down the columns. Once they are frozen, one activation vector can be presented on every cycle. Activations move rightward through the grid and partial sums move downward. Each column's dot product comes out of the bottom row.

The caller presents a whole activation vector in a single cycle. An internal delay chain staggers row r by r cycles. The results therefore leave the bottom row as a diagonal wavefront, with column c one cycle behind column c-1. Each column has its own valid flag, delayed to match that wavefront. Buffering the operands and turning the wavefront back into an aligned matrix are left to the surrounding logic.

Top module: `wsys_array`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every lane of `psum_out` is zero and every bit of `psum_vld` is low.
- R2: In a cycle with `load`=1, each cell in row 0 takes lane c of `wt_in` (bits 8c+7..8c) as its weight, and each lower cell takes the weight of the cell above it. After N load cycles, the k-th word loaded (counting from 0) is the weight set of row N-1-k.
- R3: In a cycle with `load`=0, no stored weight changes, whatever value `wt_in` carries.
- R4: The result for column c is the sum over rows r of a[r]*W[r][c]. Operands are unsigned 8-bit values, each 16-bit product is zero-extended, and the sum is 32 bits wide. The partial sum entering the top row is zero.
- R5: Lane r of `act_in` (bits 8r+7..8r) feeds row r after an internal delay of r cycles. Inside the grid an activation moves one column to the right per clock.
- R6: A vector presented in compute cycle t produces its column-c result on `psum_out` bits 32c+31..32c during cycle t+N+c. Results from consecutive vectors follow one per cycle.
- R7: `psum_vld[c]` is high exactly in the cycles of R6. Every cycle with `load`=0 and `acc_clr`=0 counts as a presented vector.
- R8: In the cycle after `acc_clr`=1, all partial sums are zero and all valid flags are low. Clearing takes priority over computing, and the stored weights are kept.
- R9: In the cycle after `load`=1, all valid flags are low. Vectors still in flight when loading starts never get a valid flag.
- R10: After a reload, the vectors presented afterwards use only the new weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | 1: shift weights down the columns; 0: compute |
| acc_clr | input | 1 | Clear all partial sums and valid flags |
| act_in | input | N*8 | Activation vector, one 8-bit lane per row |
| wt_in | input | N*8 | Weight word, one 8-bit lane per column |
| psum_out | output | N*32 | Bottom-row partial sums, one 32-bit lane per column |
| psum_vld | output | N | Per-column result valid |

## Verification
The product is exercised with several activation patterns. Uniform ones sum a whole weight column. A vector with one non-zero lane picks out a single weight row, so it exposes reversed load order or a crossed lane. Mixed values catch carries between lanes. An all-0xFF vector against all-0xFF weights reaches 260100, which only a zero-extended unsigned product gives. Identity weights echo the activation lanes back, which shows that a reload fully replaces the old weights. Toggling `wt_in` during compute, clearing mid-stream and reloading mid-stream separate the weight hold, clear priority and valid-drop behaviour. The exact output cycle of each column checks the wavefront skew.

// File: rtl/wsys_array.sv
`timescale 1ns/1ps
module wsys_array #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int SW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            acc_clr,
  input  logic [N*DW-1:0] act_in,
  input  logic [N*DW-1:0] wt_in,
  output logic [N*SW-1:0] psum_out,
  output logic [N-1:0]    psum_vld
);
  localparam int PW = 2 * DW;
  localparam int VD = 2 * N - 1;

  logic [DW-1:0] a_row [N];
  logic [DW-1:0] a_q   [N][N];
  logic [DW-1:0] w_q   [N][N];
  logic [SW-1:0] p_q   [N][N];
  logic [VD-1:0] vp;

  genvar r, c;

  for (r = 0; r < N; r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign a_row[0] = act_in[DW-1:0];
    end else begin : g_chain
      logic [DW-1:0] sk [r];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < r; k++) sk[k] <= '0;
        end else begin
          sk[0] <= act_in[r*DW +: DW];
          for (int k = 1; k < r; k++) sk[k] <= sk[k-1];
        end
      end
      assign a_row[r] = sk[r-1];
    end
  end

  for (r = 0; r < N; r++) begin : g_row
    for (c = 0; c < N; c++) begin : g_col
      logic [DW-1:0] a_in, w_in;
      logic [SW-1:0] p_in;
      logic [PW-1:0] prod;

      if (c == 0) begin : g_al
        assign a_in = a_row[r];
      end else begin : g_ai
        assign a_in = a_q[r][c-1];
      end
      if (r == 0) begin : g_top
        assign w_in = wt_in[c*DW +: DW];
        assign p_in = '0;
      end else begin : g_inner
        assign w_in = w_q[r-1][c];
        assign p_in = p_q[r-1][c];
      end

      assign prod = a_in * w_q[r][c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q[r][c] <= '0;
          w_q[r][c] <= '0;
          p_q[r][c] <= '0;
        end else begin
          a_q[r][c] <= a_in;
          if (load) w_q[r][c] <= w_in;
          p_q[r][c] <= acc_clr ? '0 : p_in + SW'(prod);
        end
      end

      p_wt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(w_q[r][c]));

      if (c > 0) begin : g_a_chk
        p_act_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> a_q[r][c] == $past(a_q[r][c-1]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               vp <= '0;
    else if (load || acc_clr) vp <= '0;
    else                      vp <= {vp[VD-2:0], 1'b1};
  end

  for (c = 0; c < N; c++) begin : g_out
    assign psum_out[c*SW +: SW] = p_q[N-1][c];
    assign psum_vld[c]          = vp[N-1+c];
    if (c > 0) begin : g_v_chk
      p_wave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !acc_clr) |=> psum_vld[c] == $past(psum_vld[c-1]));
    end
  end

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (psum_out == '0) && (psum_vld == '0));

  p_load_novld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> psum_vld == '0);

endmodule

// File: tb/test_wsys_array.sv
`timescale 1ns/1ps
module test_wsys_array;
  localparam int N = 4;

  logic         clk = 1'b0, rst_n = 1'b0, load = 1'b0, acc_clr = 1'b0;
  logic [31:0]  act_in = '0, wt_in = '0;
  logic [127:0] psum_out;
  logic [3:0]   psum_vld;

  always #2 clk = ~clk;

  wsys_array i_wsys_array (.clk, .rst_n, .load, .acc_clr, .act_in, .wt_in, .psum_out, .psum_vld);

  localparam logic [31:0] T_WT [4] = '{32'h04030201, 32'h01020304, 32'h0A00FF05, 32'h00070002};
  localparam logic [31:0] T_ID [4] = '{32'h01000000, 32'h00010000, 32'h00000100, 32'h00000001};
  localparam logic [31:0] T_FF [4] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] T_ACT [8] = '{32'h01010101, 32'h00000001, 32'h01000000, 32'h04030201,
                                        32'hFF00FF00, 32'h12345678, 32'hFFFFFFFF, 32'h80000010};

  int n_chk = 0, n_fail = 0, cyc = 0, n_rec = 0, seg = 0;
  int idx [4];
  int rec_cyc [512];
  logic [31:0] rec_act [512];
  logic [7:0]  wb [4][4];
  bit mon_en = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint dot(logic [31:0] a, int c);
    longint s = 0;
    for (int r = 0; r < N; r++) s += longint'(a[8*r +: 8]) * longint'(wb[r][c]);
    return s;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) if (mon_en) begin
    for (int c = 0; c < N; c++) if (psum_vld[c]) begin
      if (idx[c] >= n_rec) chk(0, "R9 valid without pending vector", c, -1);
      else begin
        chk(psum_out[32*c +: 32] == dot(rec_act[idx[c]], c), "R4 result (R2 R3 R5 R10)",
            psum_out[32*c +: 32], dot(rec_act[idx[c]], c));
        chk(cyc == rec_cyc[idx[c]] + N + c, "R6 output cycle", cyc, rec_cyc[idx[c]] + N + c);
        idx[c]++;
      end
    end
    if (load || acc_clr) for (int c = 0; c < N; c++) idx[c] = n_rec;
  end

  task automatic drive(bit ld, bit clr, logic [31:0] a, logic [31:0] w);
    @(posedge clk); #1;
    load = ld; acc_clr = clr; act_in = a; wt_in = w;
    if (!ld && !clr) begin
      rec_act[n_rec] = a; rec_cyc[n_rec] = cyc; n_rec++;
    end else seg = n_rec;
  endtask

  task automatic load_w(logic [31:0] words [4]);
    for (int k = 0; k < N; k++) begin
      drive(1, 0, 32'h0, words[k]);
      if (k == 1) begin
        @(negedge clk);
        chk(psum_vld == 4'b0, "R9 valid after load", psum_vld, 0);
      end
    end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wb[r][c] = words[N-1-r][8*c +: 8];
  endtask

  task automatic check_complete();
    for (int c = 0; c < N; c++) begin
      int e = seg;
      for (int k = seg; k < n_rec; k++) if (rec_cyc[k] + N + c <= cyc - 1) e++;
      chk(idx[c] == e, "R7 valid count", idx[c], e);
    end
  endtask

  task automatic stream(int first, int cnt, int tail);
    for (int i = 0; i < cnt; i++) drive(0, 0, T_ACT[(first + i) % 8], 32'h9E3779B1 * (i + 3));
    for (int i = 0; i < tail; i++) drive(0, 0, 32'h0, 32'hDEADBEEF ^ i);
    check_complete();
  endtask

  initial begin
    for (int c = 0; c < N; c++) idx[c] = 0;
    repeat (3) @(negedge clk);
    chk(psum_out == '0, "R1 psum at reset", psum_out[31:0], 0);
    chk(psum_vld == '0, "R1 valid at reset", psum_vld, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(psum_out == '0 && psum_vld == '0, "R1 after reset", psum_vld, 0);
    mon_en = 1;

    load_w(T_WT);
    stream(0, 8, 7);

    drive(0, 1, 32'h11111111, 32'h0);
    drive(0, 1, 32'h22222222, 32'h0);
    @(negedge clk);
    chk(psum_out == '0, "R8 psum after clear", psum_out[31:0], 0);
    chk(psum_vld == '0, "R8 valid after clear", psum_vld, 0);
    stream(3, 3, 7);

    stream(5, 2, 0);
    load_w(T_ID);
    stream(0, 8, 7);

    load_w(T_FF);
    drive(0, 0, 32'hFFFFFFFF, 32'h0);
    repeat (7) drive(0, 0, 32'h0, 32'h0);
    check_complete();
    chk(dot(32'hFFFFFFFF, 0) == 260100, "R4 bench model width", dot(32'hFFFFFFFF, 0), 260100);

    mon_en = 0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule